// File: doc/BRIEF.md
# Multi-Context Register Bank Controller

This block keeps several complete copies of a small processor's programmer-visible state (accumulator, two index registers, status byte, stack pointer and program counter) and decides which copy is live. The core drives a command each cycle: switch to a numbered thread, return to the thread that was live before the last switch, wait, take an interrupt, or return from an interrupt. The live copy is always shown on the read outputs. Writes from the core always land in the copy that is live in the cycle they are issued.

Changing threads only moves an on-chip index. No register contents go to memory. Each thread owns a stack page whose high address byte equals its thread number, so the block also produces the full 16-bit stack address from the live stack pointer. Thread 0 is the plain single-context thread selected at reset, thread 1 is the scheduler, and the last thread (NUM_CTX-1) serves interrupts.

Top module: `ctx_bank`

## Requirements
- R1: After reset, thread 0 is active, every field of every copy reads zero and `switch_err` is low.
- R2: A switch command (`cmd_op`=1) with an operand below NUM_CTX that differs from the active thread makes that thread active on the next cycle.
- R3: A switch command naming the thread that is already active leaves the active thread and the previous-thread record unchanged.
- R4: A switch command with an operand of NUM_CTX or more leaves the active thread unchanged and raises `switch_err` for exactly the following cycle. `switch_err` is low after every other command.
- R5: A return command (`cmd_op`=2) makes active the thread that was active just before the most recent effective switch. The record starts at 0 after reset.
- R6: A wait command (`cmd_op`=3) makes thread 1 active on the next cycle.
- R7: An interrupt entry (`cmd_op`=4) makes thread NUM_CTX-1 active and saves the interrupted thread in its own register. A return-from-interrupt (`cmd_op`=5) restores that thread even if switches happened in between.
- R8: A write issued with `wr_en` goes to the copy that is active in that cycle, even when a command in the same cycle changes the thread. All other copies keep their values.
- R9: `stack_addr` is the active thread number in bits 15:8 and the live stack pointer in bits 7:0.
- R10: `wr_field` selects the written field with this encoding: 0 A, 1 X, 2 Y, 3 status, 4 stack pointer, 5 program counter (16 bits). The 8-bit fields take `wr_data[7:0]`. Codes 6 and 7 write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_op | input | 3 | Command: 0 none, 1 switch, 2 return, 3 wait, 4 interrupt entry, 5 return from interrupt |
| cmd_arg | input | 8 | Thread operand of a switch command |
| wr_en | input | 1 | Write one field of the live copy |
| wr_field | input | 3 | Field selector for the write |
| wr_data | input | 16 | Write data |
| act_thread | output | $clog2(NUM_CTX) | Active thread number |
| rd_a | output | 8 | Live accumulator |
| rd_x | output | 8 | Live X index |
| rd_y | output | 8 | Live Y index |
| rd_p | output | 8 | Live status byte |
| rd_s | output | 8 | Live stack pointer |
| rd_pc | output | 16 | Live program counter |
| stack_addr | output | 16 | Stack address from thread number and stack pointer |
| switch_err | output | 1 | One-cycle flag for an out-of-range switch operand |

## Verification
The thread selection is tried with chains of switches, each followed by a return. A redundant switch inside such a chain shows whether the previous-thread record was wrongly overwritten. An out-of-range operand separates "ignored" from "clamped" or "wrapped". An interrupt taken in the middle of a switch chain, followed by further switches, shows whether the interrupt return uses its own saved index and not the switch record. Writes that coincide with a switch show whether the data follows the old or the new thread. A write to each field, read back after visiting other threads, shows that the copies stay apart.

// File: rtl/ctx_pkg.sv
package ctx_pkg;

  localparam int REG_W = 8;
  localparam int PC_W  = 16;

  typedef enum logic [2:0] {
    OP_NONE   = 3'd0,
    OP_SWITCH = 3'd1,
    OP_RETURN = 3'd2,
    OP_WAIT   = 3'd3,
    OP_INTR   = 3'd4,
    OP_RTI    = 3'd5
  } ctx_op_e;

  typedef enum logic [2:0] {
    FLD_A  = 3'd0,
    FLD_X  = 3'd1,
    FLD_Y  = 3'd2,
    FLD_P  = 3'd3,
    FLD_S  = 3'd4,
    FLD_PC = 3'd5
  } ctx_fld_e;

  typedef struct packed {
    logic [REG_W-1:0] a;
    logic [REG_W-1:0] x;
    logic [REG_W-1:0] y;
    logic [REG_W-1:0] p;
    logic [REG_W-1:0] s;
    logic [PC_W-1:0]  pc;
  } ctx_t;

endpackage

// File: rtl/ctx_slot.sv
module ctx_slot
  import ctx_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [2:0]      wr_field,
  input  logic [PC_W-1:0] wr_data,
  output ctx_t            ctx
);

  ctx_t ctx_q, ctx_d;

  always_comb begin
    ctx_d = ctx_q;
    if (wr_en) begin
      unique case (wr_field)
        FLD_A:   ctx_d.a  = wr_data[REG_W-1:0];
        FLD_X:   ctx_d.x  = wr_data[REG_W-1:0];
        FLD_Y:   ctx_d.y  = wr_data[REG_W-1:0];
        FLD_P:   ctx_d.p  = wr_data[REG_W-1:0];
        FLD_S:   ctx_d.s  = wr_data[REG_W-1:0];
        FLD_PC:  ctx_d.pc = wr_data;
        default: ctx_d    = ctx_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ctx_q <= '0;
    else if (wr_en) ctx_q <= ctx_d;
  end

  assign ctx = ctx_q;

endmodule

// File: rtl/ctx_select.sv
module ctx_select
  import ctx_pkg::*;
#(
  parameter int NUM_CTX = 8,
  localparam int TW = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    cmd_op,
  input  logic [7:0]    cmd_arg,
  output logic [TW-1:0] act,
  output logic          err
);

  localparam logic [TW-1:0] SCHED_ID = TW'(1);
  localparam logic [TW-1:0] INTR_ID  = TW'(NUM_CTX - 1);

  logic [TW-1:0] act_q, act_d;
  logic [TW-1:0] prev_q, prev_d;
  logic [TW-1:0] irq_q, irq_d;
  logic          err_q, err_d;
  logic          arg_ok;
  logic [TW-1:0] arg_id;

  assign arg_ok = (32'(cmd_arg) < NUM_CTX);
  assign arg_id = cmd_arg[TW-1:0];

  always_comb begin
    act_d  = act_q;
    prev_d = prev_q;
    irq_d  = irq_q;
    err_d  = 1'b0;
    unique case (cmd_op)
      OP_SWITCH: begin
        if (!arg_ok) begin
          err_d = 1'b1;
        end else if (arg_id != act_q) begin
          prev_d = act_q;
          act_d  = arg_id;
        end
      end
      OP_RETURN: act_d = prev_q;
      OP_WAIT:   act_d = SCHED_ID;
      OP_INTR: begin
        irq_d = act_q;
        act_d = INTR_ID;
      end
      OP_RTI:    act_d = irq_q;
      default:   act_d = act_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= '0;
      prev_q <= '0;
      irq_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      act_q  <= act_d;
      prev_q <= prev_d;
      irq_q  <= irq_d;
      err_q  <= err_d;
    end
  end

  assign act = act_q;
  assign err = err_q;

endmodule

// File: rtl/ctx_bank.sv
module ctx_bank
  import ctx_pkg::*;
#(
  parameter int NUM_CTX = 8,
  localparam int TW = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    cmd_op,
  input  logic [7:0]    cmd_arg,
  input  logic          wr_en,
  input  logic [2:0]    wr_field,
  input  logic [15:0]   wr_data,
  output logic [TW-1:0] act_thread,
  output logic [7:0]    rd_a,
  output logic [7:0]    rd_x,
  output logic [7:0]    rd_y,
  output logic [7:0]    rd_p,
  output logic [7:0]    rd_s,
  output logic [15:0]   rd_pc,
  output logic [15:0]   stack_addr,
  output logic          switch_err
);

  logic [TW-1:0] act;
  ctx_t          slot_ctx [NUM_CTX];
  ctx_t          live;

  ctx_select #(.NUM_CTX(NUM_CTX)) u_sel (
    .clk     (clk),
    .rst_n   (rst_n),
    .cmd_op  (cmd_op),
    .cmd_arg (cmd_arg),
    .act     (act),
    .err     (switch_err)
  );

  for (genvar g = 0; g < NUM_CTX; g++) begin : g_slot
    logic slot_we;
    assign slot_we = wr_en && (act == TW'(g));
    ctx_slot u_slot (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (slot_we),
      .wr_field (wr_field),
      .wr_data  (wr_data),
      .ctx      (slot_ctx[g])
    );
  end

  always_comb begin
    live = '0;
    for (int i = 0; i < NUM_CTX; i++) begin
      if (act == TW'(i)) live = slot_ctx[i];
    end
  end

  assign act_thread = act;
  assign rd_a       = live.a;
  assign rd_x       = live.x;
  assign rd_y       = live.y;
  assign rd_p       = live.p;
  assign rd_s       = live.s;
  assign rd_pc      = live.pc;
  assign stack_addr = {8'(act), live.s};

endmodule

// File: rtl/ctx_bank_chk.sv
module ctx_bank_chk #(
  parameter int NUM_CTX = 8,
  localparam int TW = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    cmd_op,
  input logic [7:0]    cmd_arg,
  input logic          wr_en,
  input logic [2:0]    wr_field,
  input logic [15:0]   wr_data,
  input logic [TW-1:0] act_thread,
  input logic [7:0]    rd_a,
  input logic          switch_err
);

  logic arg_ok;
  assign arg_ok = (32'(cmd_arg) < NUM_CTX);

  assert_switch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 3'd1 && arg_ok && 32'(cmd_arg) != 32'(act_thread))
      |=> 32'(act_thread) == 32'($past(cmd_arg)));

  assert_same_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 3'd1 && 32'(cmd_arg) == 32'(act_thread)) |=> $stable(act_thread));

  assert_badarg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 3'd1 && !arg_ok) |=> (switch_err && $stable(act_thread)));

  assert_errquiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op != 3'd1) |=> !switch_err);

  assert_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 3'd3) |=> (32'(act_thread) == 1));

  assert_intr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_op == 3'd4) |=> (32'(act_thread) == NUM_CTX - 1));

  assert_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_field == 3'd0 && cmd_op == 3'd0) |=> (rd_a == $past(wr_data[7:0])));

endmodule

bind ctx_bank ctx_bank_chk #(.NUM_CTX(NUM_CTX)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd_op     (cmd_op),
  .cmd_arg    (cmd_arg),
  .wr_en      (wr_en),
  .wr_field   (wr_field),
  .wr_data    (wr_data),
  .act_thread (act_thread),
  .rd_a       (rd_a),
  .switch_err (switch_err)
);

// File: tb/sim_ctx_bank.sv
`timescale 1ns/1ps
module sim_ctx_bank;

  localparam int N  = 8;
  localparam int TW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    cmd_op = '0;
  logic [7:0]    cmd_arg = '0;
  logic          wr_en = 1'b0;
  logic [2:0]    wr_field = '0;
  logic [15:0]   wr_data = '0;
  logic [TW-1:0] act_thread;
  logic [7:0]    rd_a, rd_x, rd_y, rd_p, rd_s;
  logic [15:0]   rd_pc, stack_addr;
  logic          switch_err;

  always #5 clk = ~clk;

  ctx_bank #(.NUM_CTX(N)) u0 (.*);

  typedef struct {
    string       req;
    int          thr;
    logic [7:0]  a, x, y, p, s;
    logic [15:0] pc;
    logic        err;
  } exp_t;

  exp_t exp_q[$];
  int   n_run  = 0;
  int   n_fail = 0;
  bit   done   = 0;

  int          m_thr, m_prev, m_irq;
  logic [7:0]  m_a[N], m_x[N], m_y[N], m_p[N], m_s[N];
  logic [15:0] m_pc[N];

  task automatic chk(string req, string what, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      chk(e.req, "thread", int'(act_thread), e.thr);
      chk(e.req, "a",  int'(rd_a),  int'(e.a));
      chk(e.req, "x",  int'(rd_x),  int'(e.x));
      chk(e.req, "y",  int'(rd_y),  int'(e.y));
      chk(e.req, "p",  int'(rd_p),  int'(e.p));
      chk(e.req, "pc", int'(rd_pc), int'(e.pc));
      chk(e.req, "err", int'(switch_err), int'(e.err));
      chk("R9", "stack", int'(stack_addr), (e.thr << 8) | int'(e.s));
    end
  end

  task automatic step(input logic [2:0] op, input int arg, input bit we,
                      input logic [2:0] fld, input logic [15:0] d, input string req);
    exp_t e;
    bit   err;
    @(negedge clk);
    cmd_op = op; cmd_arg = 8'(arg); wr_en = we; wr_field = fld; wr_data = d;
    @(posedge clk);
    #1;
    if (we) begin
      case (fld)
        3'd0: m_a[m_thr] = d[7:0];
        3'd1: m_x[m_thr] = d[7:0];
        3'd2: m_y[m_thr] = d[7:0];
        3'd3: m_p[m_thr] = d[7:0];
        3'd4: m_s[m_thr] = d[7:0];
        3'd5: m_pc[m_thr] = d;
        default: ;
      endcase
    end
    err = 0;
    case (op)
      3'd1: if (arg >= N) err = 1;
            else if (arg != m_thr) begin m_prev = m_thr; m_thr = arg; end
      3'd2: m_thr = m_prev;
      3'd3: m_thr = 1;
      3'd4: begin m_irq = m_thr; m_thr = N - 1; end
      3'd5: m_thr = m_irq;
      default: ;
    endcase
    e.req = req; e.thr = m_thr; e.err = err;
    e.a = m_a[m_thr]; e.x = m_x[m_thr]; e.y = m_y[m_thr];
    e.p = m_p[m_thr]; e.s = m_s[m_thr]; e.pc = m_pc[m_thr];
    exp_q.push_back(e);
  endtask

  task automatic idle(string req);
    step(3'd0, 0, 0, 3'd0, 16'h0, req);
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    m_thr = 0; m_prev = 0; m_irq = 0;
    for (int i = 0; i < N; i++) begin
      m_a[i] = 0; m_x[i] = 0; m_y[i] = 0; m_p[i] = 0; m_s[i] = 0; m_pc[i] = 0;
    end
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    idle("R1");
    // R10: each field of thread 0
    step(3'd0, 0, 1, 3'd0, 16'h0011, "R10");
    step(3'd0, 0, 1, 3'd1, 16'h0022, "R10");
    step(3'd0, 0, 1, 3'd2, 16'h0033, "R10");
    step(3'd0, 0, 1, 3'd3, 16'h0044, "R10");
    step(3'd0, 0, 1, 3'd4, 16'h00F0, "R10");
    step(3'd0, 0, 1, 3'd5, 16'hC123, "R10");
    step(3'd0, 0, 1, 3'd6, 16'h00AA, "R10");
    // R2: switch to 3, fresh copy is zero
    step(3'd1, 3, 0, 3'd0, 16'h0, "R2");
    step(3'd0, 0, 1, 3'd0, 16'h0077, "R8");
    step(3'd0, 0, 1, 3'd4, 16'h0081, "R9");
    // R3: redundant switch keeps record, then return to 0
    step(3'd1, 3, 0, 3'd0, 16'h0, "R3");
    step(3'd2, 0, 0, 3'd0, 16'h0, "R5");
    // R4: out of range operands
    step(3'd1, 9, 0, 3'd0, 16'h0, "R4");
    idle("R4");
    step(3'd1, 255, 0, 3'd0, 16'h0, "R4");
    step(3'd1, 8, 0, 3'd0, 16'h0, "R4");
    idle("R4");
    // R7: interrupt inside a switch chain
    step(3'd1, 5, 1, 3'd0, 16'h0055, "R8");
    step(3'd4, 0, 0, 3'd0, 16'h0, "R7");
    step(3'd0, 0, 1, 3'd5, 16'hBEEF, "R7");
    step(3'd1, 2, 0, 3'd0, 16'h0, "R2");
    step(3'd5, 0, 0, 3'd0, 16'h0, "R7");
    step(3'd2, 0, 0, 3'd0, 16'h0, "R5");
    // R6: wait goes to the scheduler
    step(3'd3, 0, 1, 3'd1, 16'h0066, "R6");
    step(3'd0, 0, 1, 3'd2, 16'h0099, "R6");
    // R8: write in the same cycle as a switch goes to the old thread
    step(3'd1, 4, 1, 3'd3, 16'h00C3, "R8");
    step(3'd1, 1, 0, 3'd0, 16'h0, "R8");
    step(3'd1, 0, 0, 3'd0, 16'h0, "R8");
    step(3'd1, 3, 0, 3'd0, 16'h0, "R8");
    step(3'd1, 7, 0, 3'd0, 16'h0, "R7");
    idle("R8");
    repeat (2) @(posedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule